// File: doc/BRIEF.md
# Privileged Return and Interrupt-Enable Control Unit

This unit is the system-control slice of a small in-order core. It executes the privileged special operations: interrupt disable, interrupt enable, exception return in two forms, and return from debug. It holds the processor status word with its interrupt-enable, exception-level and error-level bits, and the privilege field. It also holds the three saved return addresses (exception, error and debug), a debug-mode flag, and the load-linked address and link flag. Its output is the current operating mode.

The pipeline issues each operation as a one-cycle strobe with a 3-bit opcode. One clock later the unit answers in one of three ways. It may return the prior status word with a valid pulse, for the two enable operations. It may give a redirect address with a valid pulse, for the return operations. It may raise an illegal-operation pulse when a return is not permitted. Software loads the status word and the saved addresses through a separate write port. A load-linked strobe records a link address. A debug-entry strobe sets debug mode.

Top module: `priv_ret_unit`

## Requirements
- R1: After reset the status word holds only the error-level bit (bit 2). Interrupt-enable (bit 0) and exception-level (bit 1) are 0, debug mode is off, the link flag is clear, and the mode is kernel.
- R2: Opcode 1 (disable) drives `result_o` one cycle later with the status word as it was, with `result_valid_o` high. It clears bit 0 and leaves every other status bit unchanged.
- R3: Opcode 2 (enable) returns the prior status word the same way as R2. It sets bit 0 and leaves every other status bit unchanged.
- R4: An exception return (opcode 3 or 4) taken while bit 2 is set redirects to the error return address and clears bit 2. Bit 1 is left as it was.
- R5: An exception return taken while bit 2 is clear redirects to the exception return address and clears bit 1.
- R6: Opcode 3 also sets the link address to 1 and clears the link flag.
- R7: Opcode 4 makes the same redirect and status change as opcode 3 and leaves the link address and link flag unchanged.
- R8: Opcode 5 (debug return) clears debug mode and redirects to the debug return address. It leaves the status word unchanged.
- R9: `mode_o` is kernel (0) when bit 1 or bit 2 is set. Otherwise it follows the privilege field, bits 4:3: 00 gives kernel (0), 01 gives supervisor (1), and 10 or 11 give user (2).
- R10: Opcode 0 and the unused opcodes 6 and 7 produce no pulse and change no state.
- R11: Opcode 3 or 4 issued outside kernel mode, or opcode 5 issued outside debug mode, pulses `illegal_o` one cycle later and changes no state and produces no redirect.
- R12: A write-port access in the same cycle as a command is applied first, and the command sees the written value. Select 0 is the status word, 1 the exception return address, 2 the error return address and 3 the debug return address.
- R13: A load-linked strobe loads the link address and sets the link flag. An opcode 3 in the same cycle takes precedence.
- R14: At most one of `result_valid_o`, `redirect_valid_o` and `illegal_o` is high in any cycle, and each is high for one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| wr_en | input | 1 | Write-port strobe |
| wr_sel | input | 2 | Write-port register select |
| wr_data | input | XLEN | Write-port data |
| ll_load | input | 1 | Load-linked strobe |
| ll_load_addr | input | XLEN | Link address to record |
| dbg_enter | input | 1 | Debug-entry strobe |
| result_valid_o | output | 1 | Prior-status result valid |
| result_o | output | XLEN | Prior status word |
| redirect_valid_o | output | 1 | Redirect valid |
| redirect_pc_o | output | XLEN | Redirect address |
| illegal_o | output | 1 | Illegal-return pulse |
| status_o | output | XLEN | Current status word |
| mode_o | output | 2 | Operating mode |
| debug_mode_o | output | 1 | Debug-mode flag |
| ll_addr_o | output | XLEN | Link address |
| ll_flag_o | output | 1 | Link flag |

## Verification
Every pulse output belongs to the command sampled at the previous rising edge. The status word, mode, debug flag and link state take their new values at that same edge. The driver applies stimulus on a falling edge and queues an item tagged with its cycle number. On the next falling edge the monitor compares only the item whose tag is exactly one cycle old. This means a result that arrives a cycle early or a cycle late is reported as a miscompare.

// File: rtl/priv_ret_pkg.sv
package priv_ret_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_DI     = 3'd1,
    OP_EI     = 3'd2,
    OP_ERET   = 3'd3,
    OP_ERETNC = 3'd4,
    OP_DERET  = 3'd5
  } priv_op_e;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_SUPV = 2'd1,
    MODE_USER = 2'd2
  } priv_mode_e;

  localparam int ST_IE     = 0;
  localparam int ST_EXL    = 1;
  localparam int ST_ERL    = 2;
  localparam int ST_KSU_LO = 3;
  localparam int ST_KSU_HI = 4;

  localparam int NUM_CSR   = 4;
  localparam int SEL_STAT  = 0;
  localparam int SEL_EPC   = 1;
  localparam int SEL_ERR   = 2;
  localparam int SEL_DEPC  = 3;
endpackage

// File: rtl/priv_mode_calc.sv
module priv_mode_calc
  import priv_ret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] status,
  output logic [1:0]      mode
);
  logic [1:0] ksu;

  always_comb begin
    ksu = status[ST_KSU_HI:ST_KSU_LO];
    if (status[ST_EXL] || status[ST_ERL]) begin
      mode = MODE_KERN;
    end else begin
      unique case (ksu)
        2'b00:   mode = MODE_KERN;
        2'b01:   mode = MODE_SUPV;
        default: mode = MODE_USER;
      endcase
    end
  end
endmodule

// File: rtl/priv_csr_bank.sv
module priv_csr_bank
  import priv_ret_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SELW = $clog2(NUM_CSR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic            st_upd_en,
  input  logic [XLEN-1:0] st_upd,
  output logic [XLEN-1:0] eff [NUM_CSR],
  output logic [XLEN-1:0] cur [NUM_CSR]
);
  localparam logic [XLEN-1:0] ST_RESET = XLEN'(1) << ST_ERL;

  logic [XLEN-1:0] q_r [NUM_CSR];
  logic [XLEN-1:0] d_c [NUM_CSR];
  logic            en_c [NUM_CSR];

  for (genvar i = 0; i < NUM_CSR; i++) begin : g_csr
    logic hit;
    assign hit    = wr_en && (wr_sel == SELW'(i));
    assign eff[i] = hit ? wr_data : q_r[i];
    assign cur[i] = q_r[i];

    if (i == SEL_STAT) begin : g_stat
      always_comb begin
        en_c[i] = hit || st_upd_en;
        d_c[i]  = st_upd_en ? st_upd : wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q_r[i] <= ST_RESET;
        else if (en_c[i]) q_r[i] <= d_c[i];
      end
    end else begin : g_addr
      always_comb begin
        en_c[i] = hit;
        d_c[i]  = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q_r[i] <= '0;
        else if (en_c[i]) q_r[i] <= d_c[i];
      end
    end
  end
endmodule

// File: rtl/priv_cmd_exec.sv
module priv_cmd_exec
  import priv_ret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [XLEN-1:0] st,
  input  logic [XLEN-1:0] epc,
  input  logic [XLEN-1:0] errpc,
  input  logic [XLEN-1:0] dpc,
  input  logic [1:0]      mode,
  input  logic            dbg,
  output logic            st_upd_en,
  output logic [XLEN-1:0] st_upd,
  output logic            res_v,
  output logic [XLEN-1:0] res,
  output logic            red_v,
  output logic [XLEN-1:0] red,
  output logic            ill,
  output logic            ll_inval,
  output logic            dbg_clr
);
  localparam logic [XLEN-1:0] M_IE  = XLEN'(1) << ST_IE;
  localparam logic [XLEN-1:0] M_EXL = XLEN'(1) << ST_EXL;
  localparam logic [XLEN-1:0] M_ERL = XLEN'(1) << ST_ERL;

  logic kern;

  always_comb begin
    kern      = (mode == MODE_KERN);
    st_upd_en = 1'b0;
    st_upd    = st;
    res_v     = 1'b0;
    res       = st;
    red_v     = 1'b0;
    red       = '0;
    ill       = 1'b0;
    ll_inval  = 1'b0;
    dbg_clr   = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_DI: begin
          res_v     = 1'b1;
          st_upd_en = 1'b1;
          st_upd    = st & ~M_IE;
        end
        OP_EI: begin
          res_v     = 1'b1;
          st_upd_en = 1'b1;
          st_upd    = st | M_IE;
        end
        OP_ERET, OP_ERETNC: begin
          if (!kern) begin
            ill = 1'b1;
          end else begin
            red_v     = 1'b1;
            st_upd_en = 1'b1;
            ll_inval  = (cmd_op == OP_ERET);
            if (st[ST_ERL]) begin
              red    = errpc;
              st_upd = st & ~M_ERL;
            end else begin
              red    = epc;
              st_upd = st & ~M_EXL;
            end
          end
        end
        OP_DERET: begin
          if (!dbg) begin
            ill = 1'b1;
          end else begin
            red_v   = 1'b1;
            red     = dpc;
            dbg_clr = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/priv_ret_unit.sv
module priv_ret_unit
  import priv_ret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic            ll_load,
  input  logic [XLEN-1:0] ll_load_addr,
  input  logic            dbg_enter,
  output logic            result_valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            redirect_valid_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] status_o,
  output logic [1:0]      mode_o,
  output logic            debug_mode_o,
  output logic [XLEN-1:0] ll_addr_o,
  output logic            ll_flag_o
);
  logic [XLEN-1:0] eff [NUM_CSR];
  logic [XLEN-1:0] cur [NUM_CSR];
  logic            st_upd_en, res_v, red_v, ill, ll_inval, dbg_clr;
  logic [XLEN-1:0] st_upd, res, red;
  logic [1:0]      eff_mode;

  logic            dbg_q, dbg_d;
  logic [XLEN-1:0] lla_q, lla_d;
  logic            llf_q, llf_d, ll_en;
  logic            resv_q, redv_q, ill_q;
  logic [XLEN-1:0] res_q, red_q;

  priv_csr_bank #(.XLEN(XLEN)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .st_upd_en(st_upd_en), .st_upd(st_upd), .eff(eff), .cur(cur)
  );

  priv_mode_calc #(.XLEN(XLEN)) u_mode_eff (.status(eff[SEL_STAT]), .mode(eff_mode));
  priv_mode_calc #(.XLEN(XLEN)) u_mode_out (.status(cur[SEL_STAT]), .mode(mode_o));

  priv_cmd_exec #(.XLEN(XLEN)) u_exec (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .st(eff[SEL_STAT]), .epc(eff[SEL_EPC]),
    .errpc(eff[SEL_ERR]), .dpc(eff[SEL_DEPC]), .mode(eff_mode), .dbg(dbg_q),
    .st_upd_en(st_upd_en), .st_upd(st_upd), .res_v(res_v), .res(res),
    .red_v(red_v), .red(red), .ill(ill), .ll_inval(ll_inval), .dbg_clr(dbg_clr)
  );

  // next-state: link state and debug flag
  always_comb begin
    ll_en = ll_inval || ll_load;
    lla_d = ll_inval ? XLEN'(1) : ll_load_addr;
    llf_d = !ll_inval;
    dbg_d = dbg_enter ? 1'b1 : (dbg_clr ? 1'b0 : dbg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lla_q <= '0;
      llf_q <= 1'b0;
    end else if (ll_en) begin
      lla_q <= lla_d;
      llf_q <= llf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_q <= 1'b0;
    else        dbg_q <= dbg_d;
  end

  // response registers: pulses always loaded, data only when its pulse fires
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_q <= 1'b0;
      redv_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      resv_q <= res_v;
      redv_q <= red_v;
      ill_q  <= ill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     res_q <= '0;
    else if (res_v) res_q <= res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     red_q <= '0;
    else if (red_v) red_q <= red;
  end

  assign result_valid_o   = resv_q;
  assign result_o         = res_q;
  assign redirect_valid_o = redv_q;
  assign redirect_pc_o    = red_q;
  assign illegal_o        = ill_q;
  assign status_o         = cur[SEL_STAT];
  assign debug_mode_o     = dbg_q;
  assign ll_addr_o        = lla_q;
  assign ll_flag_o        = llf_q;

  // R2
  a_r2_di_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_DI) |=> (result_valid_o && !status_o[ST_IE]));
  // R3
  a_r3_ei_sets_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_EI) |=> (result_valid_o && status_o[ST_IE]));
  // R4
  a_r4_err_return: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ERET && !wr_en && status_o[ST_ERL])
      |=> (redirect_valid_o && !status_o[ST_ERL] && status_o[ST_EXL] == $past(status_o[ST_EXL])));
  // R6
  a_r6_link_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ERET) |=> (!redirect_valid_o || (!ll_flag_o && ll_addr_o == XLEN'(1))));
  // R11
  a_r11_deret_outside_debug: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_DERET && !debug_mode_o) |=> (illegal_o && !redirect_valid_o));
  // R14
  a_r14_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({result_valid_o, redirect_valid_o, illegal_o}));
endmodule

// File: tb/sim_priv_ret_unit.sv
module sim_priv_ret_unit;
  localparam int XLEN = 32;
  localparam int WATCHDOG = 100000;

  typedef struct {
    int          cyc;
    string       tag;
    logic        res_v;
    logic [31:0] res;
    logic        red_v;
    logic [31:0] red;
    logic        ill;
    logic [31:0] st;
    logic [1:0]  mode;
    logic        dbg;
    logic [31:0] lla;
    logic        llf;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, wr_en = 0, ll_load = 0, dbg_enter = 0;
  logic [2:0] cmd_op = 0;
  logic [1:0] wr_sel = 0;
  logic [31:0] wr_data = 0, ll_load_addr = 0;
  logic result_valid_o, redirect_valid_o, illegal_o, debug_mode_o, ll_flag_o;
  logic [31:0] result_o, redirect_pc_o, status_o, ll_addr_o;
  logic [1:0] mode_o;

  int cycle = 0, vectors = 0, fails = 0;
  bit done = 0;
  exp_t q[$];

  // model state
  logic [31:0] m_csr [4];
  logic m_dbg, m_llf;
  logic [31:0] m_lla;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  priv_ret_unit #(.XLEN(XLEN)) u0 (.*);

  function automatic logic [1:0] f_mode(logic [31:0] s);
    if (s[1] || s[2]) return 2'd0;
    case (s[4:3]) 2'b00: return 2'd0; 2'b01: return 2'd1; default: return 2'd2; endcase
  endfunction

  task automatic fail_line(string tag, string what, logic [31:0] act, logic [31:0] exp);
    fails++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic step(input string tag, input logic cv, input logic [2:0] op,
                      input logic we = 0, input logic [1:0] ws = 0, input logic [31:0] wd = 0,
                      input logic lld = 0, input logic [31:0] lla = 0, input logic de = 0);
    exp_t e;
    logic [31:0] s;
    @(negedge clk);
    cmd_valid = cv; cmd_op = op; wr_en = we; wr_sel = ws; wr_data = wd;
    ll_load = lld; ll_load_addr = lla; dbg_enter = de;
    e = '{cyc: cycle, tag: tag, default: '0};
    if (we) m_csr[ws] = wd;                 // R12: write first
    if (lld) begin m_lla = lla; m_llf = 1; end // R13
    s = m_csr[0];
    begin
      logic old_dbg;
      old_dbg = m_dbg;
      if (de) m_dbg = 1;
      if (cv) begin
        case (op)
          3'd1: begin e.res_v = 1; e.res = s; m_csr[0] = s & ~32'h1; end
          3'd2: begin e.res_v = 1; e.res = s; m_csr[0] = s | 32'h1; end
          3'd3, 3'd4: begin
            if (f_mode(s) != 2'd0) e.ill = 1;
            else begin
              e.red_v = 1;
              if (s[2]) begin e.red = m_csr[2]; m_csr[0] = s & ~32'h4; end
              else      begin e.red = m_csr[1]; m_csr[0] = s & ~32'h2; end
              if (op == 3'd3) begin m_lla = 32'd1; m_llf = 0; end
            end
          end
          3'd5: begin
            if (!old_dbg) e.ill = 1;
            else begin e.red_v = 1; e.red = m_csr[3]; if (!de) m_dbg = 0; end
          end
          default: ;
        endcase
      end
    end
    e.st = m_csr[0]; e.mode = f_mode(m_csr[0]); e.dbg = m_dbg; e.lla = m_lla; e.llf = m_llf;
    q.push_back(e);
  endtask

  // monitor: checks the item issued exactly one cycle earlier
  always @(negedge clk) begin
    if (rst_n && q.size() > 0 && q[0].cyc == cycle - 1) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (result_valid_o !== e.res_v) fail_line(e.tag, "result_valid", 32'(result_valid_o), 32'(e.res_v));
      if (e.res_v && result_o !== e.res) fail_line(e.tag, "result", result_o, e.res);
      if (redirect_valid_o !== e.red_v) fail_line(e.tag, "redirect_valid", 32'(redirect_valid_o), 32'(e.red_v));
      if (e.red_v && redirect_pc_o !== e.red) fail_line(e.tag, "redirect_pc", redirect_pc_o, e.red);
      if (illegal_o !== e.ill) fail_line(e.tag, "illegal", 32'(illegal_o), 32'(e.ill));
      if (status_o !== e.st) fail_line(e.tag, "status", status_o, e.st);
      if (mode_o !== e.mode) fail_line(e.tag, "mode", 32'(mode_o), 32'(e.mode));
      if (debug_mode_o !== e.dbg) fail_line(e.tag, "debug_mode", 32'(debug_mode_o), 32'(e.dbg));
      if (ll_addr_o !== e.lla) fail_line(e.tag, "ll_addr", ll_addr_o, e.lla);
      if (ll_flag_o !== e.llf) fail_line(e.tag, "ll_flag", 32'(ll_flag_o), 32'(e.llf));
    end
  end

  always @(posedge clk) begin
    if (!done && cycle > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycle, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    m_csr[0] = 32'h4; m_csr[1] = 0; m_csr[2] = 0; m_csr[3] = 0;
    m_dbg = 0; m_llf = 0; m_lla = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    vectors++;
    if (status_o !== 32'h4) fail_line("R1", "status", status_o, 32'h4);
    if (mode_o !== 2'd0 || debug_mode_o !== 1'b0 || ll_flag_o !== 1'b0)
      fail_line("R1", "mode/dbg/llf", {28'd0, mode_o, debug_mode_o, ll_flag_o}, 32'h0);
    // R2 / R3
    step("R2_di", 1, 3'd1);
    step("R3_ei", 1, 3'd2);
    step("R2_di_again", 1, 3'd1);
    step("R3_ei_keep_ksu", 1, 3'd2, 1, 2'd0, 32'h0000_00F8);
    // R12 address loads
    step("R12_epc", 0, 0, 1, 2'd1, 32'h0000_1000);
    step("R12_errpc", 0, 0, 1, 2'd2, 32'h0000_2000);
    step("R12_depc", 0, 0, 1, 2'd3, 32'h0000_3000);
    // R13 link load
    step("R13_ll_load", 0, 0, 0, 0, 0, 1, 32'h0000_ABC0);
    // R4 + R6: ERL and EXL set, user privilege field
    step("R4_status", 0, 0, 1, 2'd0, 32'h0000_0016);
    step("R4_R6_eret_erl", 1, 3'd3);
    // R5 + R7 + R9
    step("R13_ll_load2", 0, 0, 0, 0, 0, 1, 32'h0000_0055);
    step("R5_R7_eretnc_exl", 1, 3'd4);
    step("R9_user_mode_idle", 0, 0);
    // R11 illegal in user mode / outside debug
    step("R11_eret_user", 1, 3'd3);
    step("R11_eretnc_user", 1, 3'd4);
    step("R11_deret_nodebug", 1, 3'd5);
    // R9 supervisor
    step("R9_status_supv", 0, 0, 1, 2'd0, 32'h0000_000A);
    step("R9_eret_to_supv", 1, 3'd3);
    // R12 same-cycle write with return
    step("R12_wr_status_eret", 1, 3'd3, 1, 2'd0, 32'h0000_0006);
    step("R12_wr_epc_eret", 1, 3'd3, 1, 2'd1, 32'h0000_4444);
    // R13 load and ERET same cycle: ERET wins
    step("R13_ll_vs_eret", 1, 3'd3, 1, 2'd0, 32'h0000_0002, 1, 32'h0000_7770);
    // R8 debug return
    step("R8_dbg_enter", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R8_deret", 1, 3'd5);
    step("R8_dbg_enter2", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R8_R12_deret_wr_depc", 1, 3'd5, 1, 2'd3, 32'h0000_3300);
    // R10 opcode 0, 6, 7
    step("R10_op0", 1, 3'd0);
    step("R10_op6", 1, 3'd6);
    step("R10_op7", 1, 3'd7);
    // R14 back-to-back pulses
    step("R14_di", 1, 3'd1);
    step("R14_ei", 1, 3'd2);
    step("R14_idle", 0, 0);
    step("R14_idle2", 0, 0);
    repeat (3) @(negedge clk);
    if (q.size() != 0) fail_line("queue", "leftover", q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule